// File: doc/BRIEF.md
# PCIe TLP Trace Filter

This block sits beside a PCIe core's transaction observation point and decides, header by header, whether a transaction layer packet should be captured by a downstream trace recorder. Each observed header arrives with a valid strobe and a few pre-decoded fields: its direction relative to the core, its traffic class (posted, non-posted or completion), a completion subclass bit, the requester ID and the index of the root port it crossed. The block also carries the raw header bits alongside those fields.

Software programs three configuration words while tracing is idle. The first is a 20-bit selector that picks root-port-mask filtering or exact requester-ID filtering. The second is a type mask. The third is a direction code. A format bit tells the block whether the capture uses short (4DW) or long (8DW) records, because the direction codes mean different things in the two formats. If the configuration is illegal, the block flags it and rejects every header. One cycle after a header arrives, the block raises an accept strobe for it, together with the header and its class and direction, all aligned to that strobe.

Top module: `pcie_tlp_trace_filter`

## Requirements
- R1: Bit 19 of the filter word selects the mode: 1 selects root-port filtering and 0 selects requester-ID filtering. Bits 15:0 hold the filter value. Bits 18:16 have no effect on any decision.
- R2: In root-port mode, a header passes the filter when bit `hdr_port` of the filter value is 1. Several ports may be enabled at once.
- R3: In requester mode, a header passes the filter only when `hdr_rid` equals the 16-bit filter value exactly.
- R4: Class codes on `hdr_class` are 0 = posted, 1 = non-posted, 2 = completion and 3 = never accepted. A header passes the type check when bit `hdr_class` of the type mask is 1: bit 0 covers posted, bit 1 non-posted and bit 2 completions. Type mask bits 7:3 have no effect.
- R5: With short format (`cfg_long` = 0), the direction codes mean the following. 0 keeps all inbound headers. 1 keeps all outbound headers. 2 keeps all outbound headers plus inbound posted, inbound non-posted and inbound completion-B headers (`hdr_cpl_b` = 1). 3 keeps all outbound headers plus inbound completion-A headers (`hdr_cpl_b` = 0).
- R6: With long format (`cfg_long` = 1), the direction codes mean the following. 1 keeps all outbound headers. 2 keeps inbound posted, inbound non-posted and inbound completion-B headers. 3 keeps inbound completion-A headers. Code 0 is reserved.
- R7: `cfg_error` is high when the configuration is illegal. That is the case when the direction code is above 3, when it is 0 in long format, or when the code keeps outbound headers and the count of ones in type mask bits 2:0 is not exactly one. While `cfg_error` is high, nothing is accepted. Rewriting a legal configuration clears the flag.
- R8: After reset the configuration is inbound direction, short format and all-zero filter and type mask. `cfg_error` is low and `acc_valid` is low.
- R9: The configuration loads on a clock edge with `cfg_we` high only while `trace_en` is low. A write while `trace_en` is high has no effect.
- R10: `acc_valid` rises exactly one cycle after a header with `hdr_valid` and `trace_en` high passes the filter, type and direction checks. `acc_data`, `acc_outbound` and `acc_class` then carry that header's values. Headers seen with `trace_en` low are never accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Tracing active; configuration frozen while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_filter | input | 20 | Filter word: mode bit 19, value 15:0 |
| cfg_type | input | 8 | Type mask |
| cfg_dir | input | 4 | Direction code |
| cfg_long | input | 1 | Record format: 0 short (4DW), 1 long (8DW) |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_outbound | input | 1 | 1 outbound, 0 inbound |
| hdr_class | input | 2 | Traffic class code |
| hdr_cpl_b | input | 1 | Completion subclass: 1 = B, 0 = A |
| hdr_rid | input | 16 | Requester ID |
| hdr_port | input | PORT_W | Root port index |
| hdr_data | input | DATA_W | Raw header bits |
| acc_valid | output | 1 | Capture-accept strobe |
| acc_data | output | DATA_W | Header bits aligned to the strobe |
| acc_outbound | output | 1 | Direction aligned to the strobe |
| acc_class | output | 2 | Class aligned to the strobe |
| cfg_error | output | 1 | Illegal configuration flag |

## Verification
The assertions check on every cycle the properties that hold whatever the configuration. An illegal configuration blocks the next accept. Every accept follows an enabled, valid header and carries a class its type bit allows. An accepted outbound header implies a one-hot type mask. The configuration stays frozen while tracing runs. The exact direction tables in the two formats, the difference between the A and B completion subclasses, exact requester matching and the root-port bitmask can only be shown by the bench. It sweeps every format, direction code, type mask and filter mode against every class, subclass and direction of header.

// File: rtl/pcie_tlp_trace_filter.sv
module pcie_tlp_trace_filter #(
  parameter int DATA_W = 64,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              cfg_we,
  input  logic [19:0]       cfg_filter,
  input  logic [7:0]        cfg_type,
  input  logic [3:0]        cfg_dir,
  input  logic              cfg_long,
  input  logic              hdr_valid,
  input  logic              hdr_outbound,
  input  logic [1:0]        hdr_class,
  input  logic              hdr_cpl_b,
  input  logic [15:0]       hdr_rid,
  input  logic [PORT_W-1:0] hdr_port,
  input  logic [DATA_W-1:0] hdr_data,
  output logic              acc_valid,
  output logic [DATA_W-1:0] acc_data,
  output logic              acc_outbound,
  output logic [1:0]        acc_class,
  output logic              cfg_error
);
  localparam int VAL_W = 16;
  localparam int NPORT = 1 << PORT_W;
  localparam int MASK_W = (NPORT < VAL_W) ? NPORT : VAL_W;

  logic [19:0] r_filt;
  logic [7:0]  r_type;
  logic [3:0]  r_dir;
  logic        r_long;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_filt <= '0;
      r_type <= '0;
      r_dir  <= '0;
      r_long <= 1'b0;
    end else if (cfg_we && !trace_en) begin
      r_filt <= cfg_filter;
      r_type <= cfg_type;
      r_dir  <= cfg_dir;
      r_long <= cfg_long;
    end
  end

  wire [VAL_W-1:0]  fval      = r_filt[VAL_W-1:0];
  wire [MASK_W-1:0] port_mask = fval[MASK_W-1:0];
  wire port_hit = (int'(hdr_port) < MASK_W) && port_mask[hdr_port];
  wire rid_hit  = (hdr_rid == fval);
  wire filt_hit = r_filt[19] ? port_hit : rid_hit;

  wire is_cpl   = (hdr_class == 2'd2);
  wire type_hit = (hdr_class != 2'd3) && r_type[hdr_class];

  wire in_grp_b = !hdr_outbound && (!is_cpl || hdr_cpl_b);
  wire in_cpl_a = !hdr_outbound && is_cpl && !hdr_cpl_b;

  logic dir_hit;
  logic dir_bad;
  logic out_incl;

  always_comb begin
    dir_hit  = 1'b0;
    dir_bad  = 1'b0;
    out_incl = 1'b0;
    if (r_long) begin
      case (r_dir)
        4'd1: begin dir_hit = hdr_outbound; out_incl = 1'b1; end
        4'd2: dir_hit = in_grp_b;
        4'd3: dir_hit = in_cpl_a;
        default: dir_bad = 1'b1;
      endcase
    end else begin
      case (r_dir)
        4'd0: dir_hit = !hdr_outbound;
        4'd1: begin dir_hit = hdr_outbound; out_incl = 1'b1; end
        4'd2: begin dir_hit = hdr_outbound || in_grp_b; out_incl = 1'b1; end
        4'd3: begin dir_hit = hdr_outbound || in_cpl_a; out_incl = 1'b1; end
        default: dir_bad = 1'b1;
      endcase
    end
  end

  wire [1:0] type_cnt = 2'(r_type[0]) + 2'(r_type[1]) + 2'(r_type[2]);
  assign cfg_error = dir_bad || (out_incl && type_cnt != 2'd1);

  wire accept = trace_en && hdr_valid && !cfg_error && filt_hit && type_hit && dir_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid    <= 1'b0;
      acc_data     <= '0;
      acc_outbound <= 1'b0;
      acc_class    <= '0;
    end else begin
      acc_valid <= accept;
      if (hdr_valid) begin
        acc_data     <= hdr_data;
        acc_outbound <= hdr_outbound;
        acc_class    <= hdr_class;
      end
    end
  end

  a_r7_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> !acc_valid);

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(hdr_valid && trace_en));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trace_en) |-> ($stable(r_filt) && $stable(r_type) && $stable(r_dir) && $stable(r_long)));

  a_r4_type_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_class != 2'd3 && r_type[acc_class]));

  a_r7_outbound_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_outbound) |-> $countones(r_type[2:0]) == 1);
endmodule

// File: tb/tb_pcie_tlp_trace_filter.sv
module tb_pcie_tlp_trace_filter;
  localparam int DW = 64;
  localparam int PW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic trace_en = 0, cfg_we = 0, cfg_long = 0;
  logic [19:0] cfg_filter = '0;
  logic [7:0] cfg_type = '0;
  logic [3:0] cfg_dir = '0;
  logic hdr_valid = 0, hdr_outbound = 0, hdr_cpl_b = 0;
  logic [1:0] hdr_class = '0;
  logic [15:0] hdr_rid = '0;
  logic [PW-1:0] hdr_port = '0;
  logic [DW-1:0] hdr_data = '0;
  logic acc_valid, acc_outbound, cfg_error;
  logic [DW-1:0] acc_data;
  logic [1:0] acc_class;

  int checks = 0, fails = 0;
  logic [DW-1:0] seq = 64'h1000;

  pcie_tlp_trace_filter #(.DATA_W(DW), .PORT_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .cfg_we(cfg_we),
    .cfg_filter(cfg_filter), .cfg_type(cfg_type), .cfg_dir(cfg_dir),
    .cfg_long(cfg_long), .hdr_valid(hdr_valid), .hdr_outbound(hdr_outbound),
    .hdr_class(hdr_class), .hdr_cpl_b(hdr_cpl_b), .hdr_rid(hdr_rid),
    .hdr_port(hdr_port), .hdr_data(hdr_data), .acc_valid(acc_valid),
    .acc_data(acc_data), .acc_outbound(acc_outbound), .acc_class(acc_class),
    .cfg_error(cfg_error));

  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit exp_err(bit lng, int dir, logic [7:0] ty);
    bit incl;
    int cnt;
    cnt = int'(ty[0]) + int'(ty[1]) + int'(ty[2]);
    if (dir > 3) return 1;
    if (lng && dir == 0) return 1;
    incl = lng ? (dir == 1) : (dir != 0);
    return incl && cnt != 1;
  endfunction

  function automatic bit exp_dir(bit lng, int dir, bit ob, int cls, bit b);
    bit grpb, cpla;
    grpb = !ob && (cls != 2 || b);
    cpla = !ob && cls == 2 && !b;
    if (lng) begin
      case (dir)
        1: return ob;
        2: return grpb;
        3: return cpla;
        default: return 0;
      endcase
    end
    case (dir)
      0: return !ob;
      1: return ob;
      2: return ob || grpb;
      3: return ob || cpla;
      default: return 0;
    endcase
  endfunction

  task automatic load(input logic [19:0] f, input logic [7:0] t, input logic [3:0] d, input bit l);
    @(negedge clk);
    trace_en = 0; cfg_we = 1;
    cfg_filter = f; cfg_type = t; cfg_dir = d; cfg_long = l;
    @(negedge clk);
    cfg_we = 0; trace_en = 1;
  endtask

  task automatic send(input bit ob, input int cls, input bit b, input logic [15:0] rid,
                      input logic [PW-1:0] port, input bit exp, input string req);
    @(negedge clk);
    seq = seq + 1;
    hdr_valid = 1; hdr_outbound = ob; hdr_class = 2'(cls); hdr_cpl_b = b;
    hdr_rid = rid; hdr_port = port; hdr_data = seq;
    @(posedge clk); #1;
    hdr_valid = 0;
    chk(req, DW'(acc_valid), DW'(exp));
    if (exp && acc_valid) begin
      chk("R10 data", acc_data, seq);
      chk("R10 class", DW'(acc_class), DW'(cls));
      chk("R10 dir", DW'(acc_outbound), DW'(ob));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset valid", DW'(acc_valid), 0);
    chk("R8 reset error", DW'(cfg_error), 0);
    @(negedge clk); rst_n = 1; trace_en = 1;
    send(0, 0, 0, 16'h0000, 0, 0, "R8 default rejects (type mask zero)");

    for (int lng = 0; lng < 2; lng++)
      for (int dir = 0; dir < 5; dir++)
        for (int ty = 0; ty < 8; ty++)
          for (int md = 0; md < 2; md++) begin
            logic [19:0] f;
            logic [7:0] tyw;
            bit e;
            tyw = 8'(ty) | ((ty[0]) ? 8'hA8 : 8'h00);
            f = md ? {1'b1, 3'(ty), 16'h0024} : {1'b0, 3'(7 - ty), 16'hA5C3};
            load(f, tyw, 4'(dir), lng[0]);
            e = exp_err(lng[0], dir, tyw);
            @(posedge clk); #1;
            chk("R7 error flag", DW'(cfg_error), DW'(e));
            for (int ob = 0; ob < 2; ob++)
              for (int cls = 0; cls < 4; cls++)
                for (int b = 0; b < 2; b++)
                  for (int hit = 0; hit < 2; hit++) begin
                    logic [15:0] rid;
                    logic [PW-1:0] port;
                    bit exp;
                    if (md) begin
                      rid = 16'hA5C3;
                      port = hit ? 4'd5 : 4'd3;
                    end else begin
                      rid = hit ? 16'hA5C3 : 16'hA5C2;
                      port = 4'd5;
                    end
                    exp = !e && hit && cls != 3 && ty[cls % 3] && (cls != 3)
                          && exp_dir(lng[0], dir, ob[0], cls, b[0]);
                    send(ob[0], cls, b[0], rid, port,
                         exp, md ? "R2 R4 R5 R6 port mode" : "R3 R4 R5 R6 rid mode");
                  end
          end

    load({1'b1, 3'b000, 16'h0024}, 8'h07, 4'd0, 0);
    send(0, 1, 0, 16'h0, 4'd2, 1, "R2 port 2 enabled");
    send(0, 1, 0, 16'h0, 4'd4, 0, "R2 port 4 disabled");
    load({1'b1, 3'b111, 16'h0024}, 8'h07, 4'd0, 0);
    send(0, 1, 0, 16'h0, 4'd2, 1, "R1 reserved bits ignored");

    @(negedge clk); cfg_we = 1; cfg_filter = 20'h0; cfg_type = 8'h07; cfg_dir = 4'd1; cfg_long = 1;
    @(negedge clk); cfg_we = 0;
    chk("R9 write ignored error", DW'(cfg_error), 0);
    send(0, 1, 0, 16'h0, 4'd2, 1, "R9 write ignored accept");

    @(negedge clk); trace_en = 0;
    send(0, 1, 0, 16'h0, 4'd2, 0, "R10 disabled not accepted");

    load(20'h0, 8'h07, 4'd7, 0);
    @(posedge clk); #1;
    chk("R7 error set", DW'(cfg_error), 1);
    load({1'b1, 3'b0, 16'h0024}, 8'h01, 4'd0, 0);
    @(posedge clk); #1;
    chk("R7 error cleared", DW'(cfg_error), 0);
    send(0, 0, 0, 16'h0, 4'd5, 1, "R7 accept after rewrite");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule